// File: doc/BRIEF.md
# Post-sleep timer resynchronization calculator

This block works out where a fast free-running period timer (32 MHz) should resume after the chip has slept. During sleep only a slow 24-bit sleep counter (32 kHz) keeps running. Each job carries six values:

- the sleep counter value now and the value saved at sleep entry;
- the fast timer value and overflow count saved at sleep entry;
- the fast timer period and the overflow period.

From these the block finds how many sleep ticks went by, with wrap of the sleep counter handled. It converts the ticks to fast-clock cycles at a ratio of 15625/16 (exactly 976.5625), rounding to nearest. It adds the saved timer value and a fixed overhead of 86 cycles.

The cycle total is then split by a restoring divider, one quotient bit per clock:

- the remainder becomes the new timer value;
- the quotient is the number of timer wraps during sleep;
- the wraps plus the saved overflow count, reduced by a second division modulo the overflow period, give the new overflow count.

A period of zero stands for the full range of its field: 2^16 for the timer and 2^24 for the overflow count.

Jobs enter through a valid/ready handshake. `in_ready` is high only while the block is idle. A beat presented while `in_ready` is low is not taken and leaves no trace, so the sender must hold it until it sees ready. The result side has no back-pressure. `out_valid` pulses for one cycle, and the result ports hold their values until the next job completes. Results are exact only for sleep intervals short enough that the scaled cycle total stays within the range the caller expects. That bound depends on the timer period and on the overhead.

Top module: `sleep_resync_calc`

## Requirements
- R1: When `slp_now` is greater than `slp_saved` (both unsigned 24-bit), the elapsed tick count is `slp_now - slp_saved`.
- R2: When `slp_now` is less than or equal to `slp_saved`, the elapsed tick count is `2^24 + slp_now - slp_saved`; equal values give a full 2^24 ticks.
- R3: The cycle total is `floor((elapsed*15625 + 8) / 16) + tmr_saved + 86`, so a fraction of exactly one half rounds up.
- R4: `tmr_value` equals the cycle total modulo `tmr_period` when `tmr_period` is nonzero.
- R5: With `tmr_period` zero, `tmr_value` is the cycle total modulo 65536, and the wrap count is the total divided by 65536.
- R6: `ovf_count` equals `(total / P + ovf_saved) mod ovf_period`, where P is the effective timer period, when `ovf_period` is nonzero.
- R7: With `ovf_period` zero, `ovf_count` is `(total / P + ovf_saved) mod 2^24`.
- R8: `in_ready` is low from the cycle after a beat is accepted until the result is presented; an `in_valid` beat while `in_ready` is low is ignored and produces no result.
- R9: `out_valid` is high for exactly one cycle per accepted job, and `tmr_value` and `ovf_count` change only in that cycle.
- R10: After reset `out_valid` is 0, `in_ready` is 1 and both result ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Job beat is presented |
| in_ready | output | 1 | Block is idle and takes a beat this cycle |
| slp_now | input | 24 | Sleep counter value at wake |
| slp_saved | input | 24 | Sleep counter value saved at sleep entry |
| tmr_saved | input | 16 | Fast timer value saved at sleep entry |
| ovf_saved | input | 24 | Overflow count saved at sleep entry |
| tmr_period | input | 16 | Fast timer period (0 means 65536) |
| ovf_period | input | 24 | Overflow period (0 means 2^24) |
| out_valid | output | 1 | One-cycle pulse: result ports are new |
| tmr_value | output | 16 | Resumed timer value |
| ovf_count | output | 24 | Resumed overflow count |

## Verification
The assertions check the invariants that hold on every cycle. Ready stays low while a job is in flight, and the result pulse lasts a single cycle. The result ports stay stable outside that pulse. Each result lies below the period it was reduced by, and every remainder from the divider lies below its divisor.

The arithmetic can only be shown by scenarios whose values the bench computes independently: wrap of the sleep counter, equal counter values, the half-up rounding point, zero periods and carries into the overflow count. Discarding a beat offered while busy can only be shown through the result ports.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCALE,
    ST_DIVT,
    ST_DIVO
  } srs_state_e;

  localparam int unsigned SRS_RATIO_NUM   = 15625;
  localparam int unsigned SRS_RATIO_SHIFT = 4;
  localparam int unsigned SRS_OVERHEAD    = 86;
endpackage

// File: rtl/srs_tick_scale.sv
module srs_tick_scale #(
  parameter int unsigned SLP_W = 24,
  parameter int unsigned TMR_W = 16,
  parameter int unsigned NUM   = 15625,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned OVH   = 86,
  parameter int unsigned TOT_W = 36
) (
  input  logic [SLP_W-1:0] slp_now,
  input  logic [SLP_W-1:0] slp_saved,
  input  logic [TMR_W-1:0] tmr_saved,
  output logic [TOT_W-1:0] total
);
  localparam int unsigned EL_W   = SLP_W + 1;
  localparam int unsigned NUM_W  = $clog2(NUM + 1);
  localparam int unsigned PROD_W = EL_W + NUM_W;

  logic [EL_W-1:0]   diff;
  logic [EL_W-1:0]   elapsed;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] rounded;

  // Elapsed ticks: the plain difference, or one full counter span added
  // when the counter has wrapped (or came back to the same value).
  always_comb begin
    diff = {1'b0, slp_now} - {1'b0, slp_saved};
    if (slp_now > slp_saved) elapsed = diff;
    else                     elapsed = diff + (EL_W'(1) << SLP_W);
    prod    = PROD_W'(elapsed) * PROD_W'(NUM);
    rounded = (prod + (PROD_W'(1) << (SHIFT - 1))) >> SHIFT;
    total   = TOT_W'(rounded) + TOT_W'(tmr_saved) + TOT_W'(OVH);
  end
endmodule

// File: rtl/srs_restoring_div.sv
module srs_restoring_div #(
  parameter int unsigned DW = 36,
  parameter int unsigned VW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quot,
  output logic [VW-1:0] rem
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] dq;
  logic [VW-1:0] r;
  logic [VW-1:0] dvs;
  logic [CW-1:0] cnt;
  logic [VW:0]   trial;
  logic [VW:0]   sub;
  logic          take;

  always_comb begin
    trial = {r, dq[DW-1]};
    sub   = trial - {1'b0, dvs};
    take  = (trial >= {1'b0, dvs});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq   <= '0;
      r    <= '0;
      dvs  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dq   <= dividend;
        dvs  <= divisor;
        r    <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        dq  <= {dq[DW-2:0], take};
        r   <= take ? sub[VW-1:0] : trial[VW-1:0];
        cnt <= cnt + CW'(1);
        if (cnt == CW'(DW - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = dq;
  assign rem  = r;

  // R4: each finished remainder lies below the divisor it was reduced by.
  p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem < dvs));

  // R8: a new division is only launched when the unit is free.
  p_start_when_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/sleep_resync_calc.sv
module sleep_resync_calc
  import srs_pkg::*;
#(
  parameter int unsigned SLP_W = 24,
  parameter int unsigned TMR_W = 16,
  parameter int unsigned OVF_W = 24,
  parameter int unsigned NUM   = SRS_RATIO_NUM,
  parameter int unsigned SHIFT = SRS_RATIO_SHIFT,
  parameter int unsigned OVH   = SRS_OVERHEAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SLP_W-1:0] slp_now,
  input  logic [SLP_W-1:0] slp_saved,
  input  logic [TMR_W-1:0] tmr_saved,
  input  logic [OVF_W-1:0] ovf_saved,
  input  logic [TMR_W-1:0] tmr_period,
  input  logic [OVF_W-1:0] ovf_period,
  output logic             out_valid,
  output logic [TMR_W-1:0] tmr_value,
  output logic [OVF_W-1:0] ovf_count
);
  localparam int unsigned NUM_W  = $clog2(NUM + 1);
  localparam int unsigned PROD_W = SLP_W + 1 + NUM_W;
  localparam int unsigned TOT_W  = PROD_W - SHIFT + 1;
  localparam int unsigned TVW    = TMR_W + 1;
  localparam int unsigned OVW    = OVF_W + 1;
  localparam int unsigned ODW    = TOT_W + 1;

  srs_state_e       state;
  logic [SLP_W-1:0] now_q, saved_q;
  logic [TMR_W-1:0] tsav_q, tper_q;
  logic [OVF_W-1:0] osav_q, oper_q;
  logic             accept;

  logic [TOT_W-1:0] total;
  logic [TVW-1:0]   t_divisor;
  logic [OVW-1:0]   o_divisor;
  logic [ODW-1:0]   o_dividend;

  logic             t_start, t_busy, t_done;
  logic [TOT_W-1:0] t_quot;
  logic [TVW-1:0]   t_rem;
  logic             o_start, o_busy, o_done;
  logic [ODW-1:0]   o_quot;
  logic [OVW-1:0]   o_rem;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;

  srs_tick_scale #(
    .SLP_W(SLP_W), .TMR_W(TMR_W), .NUM(NUM),
    .SHIFT(SHIFT), .OVH(OVH), .TOT_W(TOT_W)
  ) u_scale (
    .slp_now  (now_q),
    .slp_saved(saved_q),
    .tmr_saved(tsav_q),
    .total    (total)
  );

  // A zero period selects the full field range as divisor.
  always_comb begin
    t_divisor  = (tper_q == '0) ? (TVW'(1) << TMR_W) : TVW'(tper_q);
    o_divisor  = (oper_q == '0) ? (OVW'(1) << OVF_W) : OVW'(oper_q);
    o_dividend = ODW'(t_quot) + ODW'(osav_q);
    t_start    = (state == ST_SCALE);
    o_start    = (state == ST_DIVT) && t_done;
  end

  srs_restoring_div #(.DW(TOT_W), .VW(TVW)) u_div_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (t_start),
    .dividend(total),
    .divisor (t_divisor),
    .busy    (t_busy),
    .done    (t_done),
    .quot    (t_quot),
    .rem     (t_rem)
  );

  srs_restoring_div #(.DW(ODW), .VW(OVW)) u_div_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (o_start),
    .dividend(o_dividend),
    .divisor (o_divisor),
    .busy    (o_busy),
    .done    (o_done),
    .quot    (o_quot),
    .rem     (o_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      now_q     <= '0;
      saved_q   <= '0;
      tsav_q    <= '0;
      tper_q    <= '0;
      osav_q    <= '0;
      oper_q    <= '0;
      out_valid <= 1'b0;
      tmr_value <= '0;
      ovf_count <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          now_q   <= slp_now;
          saved_q <= slp_saved;
          tsav_q  <= tmr_saved;
          tper_q  <= tmr_period;
          osav_q  <= ovf_saved;
          oper_q  <= ovf_period;
          state   <= ST_SCALE;
        end
        ST_SCALE: state <= ST_DIVT;
        ST_DIVT:  if (t_done) state <= ST_DIVO;
        ST_DIVO:  if (o_done) begin
          tmr_value <= t_rem[TMR_W-1:0];
          ovf_count <= o_rem[OVF_W-1:0];
          out_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: no beat is taken while either divider is working.
  p_not_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (t_busy || o_busy) |-> !in_ready);

  // R9: the result strobe lasts one cycle.
  p_out_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9: results hold outside the strobe.
  p_hold_tmr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(tmr_value) && $stable(ovf_count)));

  // R4: the timer result lies below a nonzero period.
  p_tmr_below_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tper_q != '0) |-> (tmr_value < tper_q));

  // R6: the overflow result lies below a nonzero overflow period.
  p_ovf_below_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && oper_q != '0) |-> (ovf_count < oper_q));
endmodule

// File: tb/sleep_resync_calc_tb.sv
module sleep_resync_calc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // fields: slp_now, slp_saved, tmr_saved, ovf_saved, tmr_period, ovf_period
  localparam logic [127:0] VEC [NVEC] = '{
    {24'd10,       24'd0,        16'd0,     24'd0,       16'd1000,  24'd0},
    {24'd5000,     24'd1200,     16'd777,   24'd12,      16'd40000, 24'd100},
    {24'd100,      24'd16777000, 16'd5,     24'd3,       16'd31250, 24'd50000},
    {24'd1,        24'd2,        16'd65535, 24'd16777215,16'd0,     24'd0},
    {24'd16777215, 24'd0,        16'd123,   24'd0,       16'd1,     24'd7},
    {24'd333333,   24'd11,       16'd9999,  24'd999,     16'd65535, 24'd1000},
    {24'd7,        24'd4,        16'd0,     24'd16777214,16'd3,     24'd0},
    {24'd42,       24'd42,       16'd300,   24'd5,       16'd12345, 24'd16777215}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] slp_now = '0, slp_saved = '0, ovf_saved = '0, ovf_period = '0;
  logic [15:0] tmr_saved = '0, tmr_period = '0;
  logic        out_valid;
  logic [15:0] tmr_value;
  logic [23:0] ovf_count;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_resync_calc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .slp_now(slp_now), .slp_saved(slp_saved), .tmr_saved(tmr_saved),
    .ovf_saved(ovf_saved), .tmr_period(tmr_period), .ovf_period(ovf_period),
    .out_valid(out_valid), .tmr_value(tmr_value), .ovf_count(ovf_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic [127:0] v,
                                output longint et, output longint eo);
    longint d, c, p, q, po;
    d = longint'(v[127:104]) - longint'(v[103:80]);
    if (d <= 0) d = d + (64'd1 << 24);
    c = ((d * 15625 + 8) >> 4) + longint'(v[79:64]) + 86;
    p = (v[39:24] == 0) ? 65536 : longint'(v[39:24]);
    q = c / p;
    et = c % p;
    po = (v[23:0] == 0) ? (64'd1 << 24) : longint'(v[23:0]);
    eo = (q + longint'(v[63:40])) % po;
  endfunction

  task automatic apply(input logic [127:0] v);
    while (!in_ready) @(negedge clk);
    {slp_now, slp_saved, tmr_saved, ovf_saved, tmr_period, ovf_period} = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_result(output bit got);
    got = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (out_valid) begin got = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint et, eo;
    bit got;
    logic [15:0] held_t;
    logic [23:0] held_o;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", longint'(out_valid), 0);
    check("R10 in_ready", longint'(in_ready), 1);
    check("R10 tmr_value", longint'(tmr_value), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ovf_count", longint'(ovf_count), 0);

    // Vector table: R1 R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      model(VEC[k], et, eo);
      apply(VEC[k]);
      wait_result(got);
      check("R9 result presented", longint'(got), 1);
      check("R4/R5 tmr_value R1 R2 R3", longint'(tmr_value), et);
      check("R6/R7 ovf_count", longint'(ovf_count), eo);
      @(negedge clk);
      check("R9 single pulse", longint'(out_valid), 0);
    end

    // R3 half rounds up: 8 ticks -> 7812.5 -> 7813, +86
    apply({24'd8, 24'd0, 16'd0, 24'd0, 16'd0, 24'd0});
    wait_result(got);
    check("R3 half-up rounding", longint'(tmr_value), 7899);
    check("R1 ovf zero", longint'(ovf_count), 0);

    // R2 equal values give 2^24 ticks: total 16384000086; R5 mod 65536 -> 86, wraps 250000; R7
    apply({24'd77, 24'd77, 16'd0, 24'd10, 16'd0, 24'd0});
    wait_result(got);
    check("R2 R5 full span tmr", longint'(tmr_value), 86);
    check("R2 R7 full span ovf", longint'(ovf_count), 250010);

    // R9 hold: results stable, block idle afterwards
    held_t = tmr_value;
    held_o = ovf_count;
    repeat (5) @(negedge clk);
    check("R9 hold tmr", longint'(tmr_value), longint'(held_t));
    check("R9 hold ovf", longint'(ovf_count), longint'(held_o));

    // R8 beat while busy is ignored
    model(VEC[1], et, eo);
    apply(VEC[1]);
    check("R8 not ready while busy", longint'(in_ready), 0);
    {slp_now, slp_saved, tmr_saved, ovf_saved, tmr_period, ovf_period} = VEC[2];
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    wait_result(got);
    check("R8 first job result tmr", longint'(tmr_value), et);
    check("R8 first job result ovf", longint'(ovf_count), eo);
    wait_result(got);
    check("R8 no result for dropped beat", longint'(got), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule